// File: doc/BRIEF.md
# Programmable Down-Counting Timer Channel

This block is one channel of a programmable interval timer. It counts down from an initial count on each pulse of a count-enable strobe, which is separate from the system clock. A gate input can pause counting or restart it. An output line produces one of six waveforms: a terminal-count level, a hardware-triggered one-shot, a rate pulse, a square wave, a software strobe or a hardware-triggered strobe. Counting can be binary or four-digit decimal (BCD). The live count value is available on a port every cycle, so a register interface next to the channel can take a snapshot of it at any time. Decoding the control word and sequencing bytes are done by that register interface, not here.

A load is a single-cycle strobe that carries a mode, a BCD flag and an initial count. It has no back-pressure: the strobe is accepted in every cycle. A second strobe sent before the channel uses the first one replaces it. The pending configuration takes effect on the next count-enable strobe. Until then the previous configuration keeps running. In the equations below, N is the initial count and k is the number of counting strobes since the load was applied or since the last trigger.

Top module: `down_timer_channel`

## Requirements
- R1: After reset the count output is 0 and the timer output is low. Both stay that way, whatever the strobes, until a load is applied.
- R2: A load takes effect on the first count-enable strobe after it. Until that strobe the count output and the timer output keep their previous values. If two loads arrive before that strobe, the later one is used. An initial count of 0 means 65536 in binary and 10000 in BCD, and the count output shows 0 in that state.
- R3: Mode 0 (mode code 0): the output goes low when the load is applied. It goes high on the strobe that takes the count to 0 and then stays high. The counter keeps counting down and wraps from 0 to FFFF hex, or to 9999 in BCD. While the gate is low, strobes do not change the count.
- R4: Mode 1 (mode code 1): after the load is applied, the count holds at N and the output stays high until a rising edge is seen on the gate. On the next strobe after that edge, the count reloads to N and the output goes low. The output goes high again when the count reaches 0. Another rising edge restarts the cycle. The gate level does not pause counting.
- R5: Mode 2 (mode code 2): the output repeats with a period of N strobes. At strobe k the count is N - (k mod N). The output is low only on the strobe where the count is 1, and it is high on the strobe that applies the load. The count then reloads to N.
- R6: Mode 3 (mode code 3): the output repeats with a period of N strobes. It is high for the first (N+1)/2 strobes (rounded down) and low for the rest. The count steps by 2 on each strobe. In the high phase it starts from N, and in the low phase from N with bit 0 cleared.
- R7: Mode 4 (mode code 4): the output is high. It drops for exactly one strobe, on the strobe that takes the count to 0, and this happens only once after each load, even after the counter wraps. While the gate is low, strobes do not change the count.
- R8: Mode 5 (mode code 5): the behaviour is that of mode 4, except that counting starts from N on the strobe after a gate rising edge. Each further rising edge restarts the count and re-enables the single low strobe. The gate level does not pause counting.
- R9: In modes 2 and 3, a low gate stops counting and forces the output high within one clock. A later rising edge on the gate restarts the period from N, with the output high, on the next strobe.
- R10: With the BCD flag set, and a valid BCD initial count, every digit of the count stays in the range 0 to 9. Decrements borrow across decimal digits.
- R11: Mode codes 6 and 7 behave exactly as mode codes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count-enable strobe, one clock wide per count |
| gate_i | input | 1 | Gate level; its rising edges are triggers |
| ld_i | input | 1 | Load strobe for mode, BCD flag and initial count |
| ld_mode_i | input | 3 | Mode code 0 to 7 |
| ld_bcd_i | input | 1 | 1 selects four-digit decimal counting |
| ld_val_i | input | 16 | Initial count (0 means the full range) |
| cnt_o | output | 16 | Live count value |
| out_o | output | 1 | Timer output waveform |

## Verification
The hardest behaviour to reach from the ports is the single-strobe rule of mode 4 after the counter wraps. A second terminal count takes a full range of strobes. The stimulus runs this case in BCD, where the full range is 10,000 strobes instead of 65,536, and it checks every strobe until the counter has passed 0 a second time. The stimulus also sends gate edges between strobes, so that a trigger is registered before the strobe that consumes it. On top of these directed cases it uses random counts, modes and run lengths.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  typedef enum logic [2:0] {
    MD_TERM    = 3'd0,
    MD_ONESHOT = 3'd1,
    MD_RATE    = 3'd2,
    MD_SQUARE  = 3'd3,
    MD_SWSTB   = 3'd4,
    MD_HWSTB   = 3'd5
  } md_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } st_e;

  // codes 6 and 7 fold onto the two periodic modes
  function automatic md_e fold_mode(input logic [2:0] raw);
    logic [2:0] m;
    m = raw;
    if (raw[2] && raw[1]) m = {1'b0, raw[1:0]};
    return md_e'(m);
  endfunction

  function automatic logic needs_trigger(input md_e m);
    return (m == MD_ONESHOT) || (m == MD_HWSTB);
  endfunction

  function automatic logic gate_restarts(input md_e m);
    return (m == MD_ONESHOT) || (m == MD_RATE) || (m == MD_SQUARE) || (m == MD_HWSTB);
  endfunction

  function automatic logic gate_ignored(input md_e m);
    return (m == MD_ONESHOT) || (m == MD_HWSTB);
  endfunction

  function automatic logic is_periodic(input md_e m);
    return (m == MD_RATE) || (m == MD_SQUARE);
  endfunction

endpackage

// File: rtl/dtc_load_hold.sv
module dtc_load_hold
  import dtc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic [2:0]    ld_mode_i,
  input  logic          ld_bcd_i,
  input  logic [CW-1:0] ld_val_i,
  input  logic          take_i,
  output logic          pend_o,
  output md_e           mode_o,
  output logic          bcd_o,
  output logic [CW:0]   full_o
);

  logic [CW-1:0] val_q;
  logic          pend_q;
  md_e           mode_q;
  logic          bcd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      mode_q <= MD_TERM;
      bcd_q  <= 1'b0;
      val_q  <= '0;
    end else begin
      if (ld_i) begin
        pend_q <= 1'b1;
        mode_q <= fold_mode(ld_mode_i);
        bcd_q  <= ld_bcd_i;
        val_q  <= ld_val_i;
      end else if (take_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  // zero selects the full range: one digit above the top of the field
  assign full_o = (val_q == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, val_q};
  assign pend_o = pend_q;
  assign mode_o = mode_q;
  assign bcd_o  = bcd_q;

endmodule

// File: rtl/dtc_gate_edge.sv
module dtc_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  input  logic tick_i,
  output logic trig_o
);

  logic gate_q;
  logic held_q;
  logic rise;

  assign rise = gate_i & ~gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= 1'b1;
      held_q <= 1'b0;
    end else begin
      gate_q <= gate_i;
      if (tick_i) held_q <= 1'b0;
      else if (rise) held_q <= 1'b1;
    end
  end

  assign trig_o = held_q | rise;

endmodule

// File: rtl/dtc_decrement.sv
module dtc_decrement #(
  parameter int CW = 16
) (
  input  logic [CW:0] val_i,
  input  logic        bcd_i,
  output logic [CW:0] res_o
);

  localparam int DIG = CW / 4;

  logic [DIG-1:0] zero_v;

  for (genvar g = 0; g < DIG; g++) begin : g_dig
    logic [3:0] nib;
    logic       brw;
    assign nib       = val_i[4*g +: 4];
    assign zero_v[g] = (nib == 4'd0);
    if (g == 0) begin : g_lsd
      assign brw = 1'b1;
    end else begin : g_upper
      assign brw = &zero_v[g-1:0];
    end
    assign res_o[4*g +: 4] = !brw ? nib :
                             (zero_v[g] ? (bcd_i ? 4'd9 : 4'hF) : nib - 4'd1);
  end

  // the extra top bit only represents the full-range value
  assign res_o[CW] = val_i[CW] & ~(&zero_v);

endmodule

// File: rtl/down_timer_channel.sv
module down_timer_channel
  import dtc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          gate_i,
  input  logic          ld_i,
  input  logic [2:0]    ld_mode_i,
  input  logic          ld_bcd_i,
  input  logic [CW-1:0] ld_val_i,
  output logic [CW-1:0] cnt_o,
  output logic          out_o
);

  localparam int LW  = CW + 1;
  localparam int DIG = CW / 4;

  logic        pend;
  md_e         p_mode;
  logic        p_bcd;
  logic [CW:0] p_full;
  logic        trig;

  logic [CW:0] cnt_q, init_q, dec1, dec2;
  md_e         mode_q;
  logic        bcd_q, out_q, fired_q;
  st_e         st_q;

  dtc_load_hold #(.CW(CW)) u_hold (
    .clk(clk), .rst_n(rst_n), .ld_i(ld_i), .ld_mode_i(ld_mode_i),
    .ld_bcd_i(ld_bcd_i), .ld_val_i(ld_val_i), .take_i(tick_i),
    .pend_o(pend), .mode_o(p_mode), .bcd_o(p_bcd), .full_o(p_full)
  );

  dtc_gate_edge u_edge (
    .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .tick_i(tick_i), .trig_o(trig)
  );

  dtc_decrement #(.CW(CW)) u_dec1 (.val_i(cnt_q), .bcd_i(bcd_q), .res_o(dec1));
  dtc_decrement #(.CW(CW)) u_dec2 (.val_i(dec1),  .bcd_i(bcd_q), .res_o(dec2));

  logic counting_ok, dec1_zero, dec1_one, cnt_one, sq_term, do_retrig;

  assign counting_ok = (st_q == ST_RUN) && (gate_i || gate_ignored(mode_q));
  assign dec1_zero   = (dec1 == '0);
  assign dec1_one    = (dec1 == LW'(1));
  assign cnt_one     = (cnt_q == LW'(1));
  assign sq_term     = !cnt_q[CW] && (cnt_q[CW-1:0] <= CW'(2));
  assign do_retrig   = trig && (st_q != ST_IDLE) && gate_restarts(mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      init_q  <= '0;
      mode_q  <= MD_TERM;
      bcd_q   <= 1'b0;
      st_q    <= ST_IDLE;
      out_q   <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      if (is_periodic(mode_q) && (st_q != ST_IDLE) && !gate_i) out_q <= 1'b1;
      if (tick_i) begin
        if (pend) begin
          mode_q  <= p_mode;
          bcd_q   <= p_bcd;
          init_q  <= p_full;
          cnt_q   <= p_full;
          fired_q <= 1'b0;
          out_q   <= (p_mode != MD_TERM);
          st_q    <= needs_trigger(p_mode) ? ST_ARMED : ST_RUN;
        end else if (do_retrig) begin
          cnt_q   <= init_q;
          fired_q <= 1'b0;
          st_q    <= ST_RUN;
          out_q   <= (mode_q != MD_ONESHOT);
        end else if (counting_ok) begin
          unique case (mode_q)
            MD_TERM, MD_ONESHOT: begin
              cnt_q <= dec1;
              if (dec1_zero) out_q <= 1'b1;
            end
            MD_SWSTB, MD_HWSTB: begin
              cnt_q <= dec1;
              out_q <= 1'b1;
              if (dec1_zero && !fired_q) begin
                out_q   <= 1'b0;
                fired_q <= 1'b1;
              end
            end
            MD_RATE: begin
              if (cnt_one) begin
                cnt_q <= init_q;
                out_q <= 1'b1;
              end else begin
                cnt_q <= dec1;
                out_q <= !dec1_one;
              end
            end
            MD_SQUARE: begin
              if (sq_term) begin
                out_q <= !out_q;
                cnt_q <= out_q ? {init_q[CW:1], 1'b0} : init_q;
              end else begin
                cnt_q <= dec2;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign cnt_o = cnt_q[CW-1:0];
  assign out_o = out_q;

  logic digits_ok;
  always_comb begin
    digits_ok = 1'b1;
    for (int d = 0; d < DIG; d++) begin
      if (cnt_q[4*d +: 4] > 4'd9) digits_ok = 1'b0;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> (cnt_q == '0) && !out_q);

  assert_apply_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && pend) |=> (cnt_q == $past(p_full)));

  assert_m0_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_TERM && out_q && !(tick_i && pend)) |=> out_q);

  assert_suspend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_TERM || mode_q == MD_SWSTB) && !gate_i && !(tick_i && pend))
      |=> $stable(cnt_q));

  assert_m1_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !pend && trig && mode_q == MD_ONESHOT && st_q != ST_IDLE)
      |=> !out_q && (cnt_q == $past(init_q)));

  assert_m2_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_RATE && !out_q && tick_i && !pend) |=> out_q);

  assert_m3_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_SQUARE && counting_ok && tick_i && !pend && !trig && !bcd_q && !sq_term)
      |=> (cnt_q == $past(cnt_q) - LW'(2)));

  assert_m4_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_SWSTB && fired_q && out_q && !(tick_i && pend)) |=> out_q);

  assert_m5_trigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !pend && trig && mode_q == MD_HWSTB && st_q != ST_IDLE)
      |=> out_q && (cnt_q == $past(init_q)));

  assert_gate_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_periodic(mode_q) && st_q != ST_IDLE && !gate_i && !(tick_i && pend)) |=> out_q);

  assert_bcd_digits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bcd_q && st_q != ST_IDLE) |-> digits_ok);

  assert_mode_fold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && ld_mode_i[2] && ld_mode_i[1] && !ld_i) |-> (p_mode != MD_TERM || 1'b1) && (p_mode <= MD_HWSTB));

endmodule

// File: tb/sim_down_timer_channel.sv
module sim_down_timer_channel;

  localparam int CLK_P = 10;
  localparam int SEED  = 7411;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        gate = 1'b1;
  logic        ld = 1'b0;
  logic [2:0]  ld_mode = 3'd0;
  logic        ld_bcd = 1'b0;
  logic [15:0] ld_val = 16'd0;
  logic [15:0] cnt;
  logic        out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  down_timer_channel u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .gate_i(gate), .ld_i(ld),
    .ld_mode_i(ld_mode), .ld_bcd_i(ld_bcd), .ld_val_i(ld_val),
    .cnt_o(cnt), .out_o(out)
  );

  function automatic int to_bcd(input int v);
    return ((v / 1000) % 10) * 4096 + ((v / 100) % 10) * 256 + ((v / 10) % 10) * 16 + (v % 10);
  endfunction

  function automatic int enc(input int v, input bit bcd);
    if (bcd) return to_bcd(v % 10000);
    return v & 16'hFFFF;
  endfunction

  function automatic int wrapd(input int n, input int k, input bit bcd);
    int m;
    m = bcd ? 10000 : 65536;
    return enc(((n - k) % m + m) % m, bcd);
  endfunction

  // expected count and output k strobes after apply or trigger
  function automatic int exp_cnt(input int md, input int n, input int k, input bit bcd);
    int p, h;
    case (md)
      2: begin p = k % n; return enc(n - p, bcd); end
      3: begin
        p = k % n; h = (n + 1) / 2;
        if (p < h) return enc(n - 2 * p, bcd);
        return enc((n & ~1) - 2 * (p - h), bcd);
      end
      default: return wrapd(n, k, bcd);
    endcase
  endfunction

  function automatic bit exp_out(input int md, input int n, input int k);
    case (md)
      0, 1: return k >= n;
      2: return (k % n) != (n - 1);
      3: return (k % n) < ((n + 1) / 2);
      default: return k != n;
    endcase
  endfunction

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  task automatic chk(input string req, input int got, input int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, got, expv, $time);
    end
  endtask

  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_load(input int md, input bit bcd, input int v);
    ld = 1'b1; ld_mode = 3'(md); ld_bcd = bcd; ld_val = 16'(v);
    @(negedge clk);
    ld = 1'b0;
  endtask

  task automatic set_gate(input bit v);
    gate = v;
    @(negedge clk);
  endtask

  task automatic step_check(input string req, input int md, input int n, input int k, input bit bcd);
    do_tick();
    chk({req, " count"}, int'(cnt), exp_cnt(md, n, k, bcd));
    chk({req, " out"}, int'(out), int'(exp_out(md, n, k)));
  endtask

  initial begin
    #(CLK_P * 190000);
    checks++; errors++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    int r;
    r = $urandom(SEED);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, strobes without a load change nothing
    chk("R1 reset count", int'(cnt), 0);
    chk("R1 reset out", int'(out), 0);
    repeat (3) do_tick();
    chk("R1 idle count", int'(cnt), 0);
    chk("R1 idle out", int'(out), 0);

    // R3: terminal count level with wrap
    do_load(0, 0, 5);
    chk("R2 not applied yet", int'(cnt), 0);
    for (int k = 0; k <= 8; k++) step_check("R3 mode0", 0, 5, k, 0);

    // R2: previous count holds until the strobe
    do_load(2, 0, 9);
    repeat (2) @(negedge clk);
    chk("R2 hold count", int'(cnt), 16'hFFFD);
    chk("R2 hold out", int'(out), 1);

    // R3: gate low suspends
    do_load(0, 0, 10);
    for (int k = 0; k <= 3; k++) step_check("R3 gated", 0, 10, k, 0);
    set_gate(0);
    repeat (4) do_tick();
    chk("R3 suspended count", int'(cnt), 7);
    set_gate(1);
    for (int k = 4; k <= 11; k++) step_check("R3 resumed", 0, 10, k, 0);

    // R2: the later of two loads wins; zero is the full range
    do_load(0, 0, 100);
    do_load(0, 0, 7);
    step_check("R2 last load", 0, 7, 0, 0);
    do_load(0, 0, 0);
    step_check("R2 full binary", 0, 65536, 0, 0);
    step_check("R2 full binary", 0, 65536, 1, 0);

    // R10: decimal counting and wrap to 9999
    do_load(0, 1, 16'h0012);
    for (int k = 0; k <= 14; k++) step_check("R10 bcd", 0, 12, k, 1);
    do_load(0, 1, 0);
    step_check("R2 full bcd", 0, 10000, 0, 1);
    step_check("R10 full bcd", 0, 10000, 1, 1);

    // R5: rate pulses
    do_load(2, 0, 4);
    for (int k = 0; k <= 12; k++) step_check("R5 rate", 2, 4, k, 0);

    // R6: square wave, odd and even
    do_load(3, 0, 5);
    for (int k = 0; k <= 15; k++) step_check("R6 square odd", 3, 5, k, 0);
    do_load(3, 0, 6);
    for (int k = 0; k <= 13; k++) step_check("R6 square even", 3, 6, k, 0);

    // R9: gate low in square mode, then restart
    do_load(3, 0, 8);
    for (int k = 0; k <= 5; k++) step_check("R9 pre", 3, 8, k, 0);
    set_gate(0);
    chk("R9 forced high", int'(out), 1);
    repeat (3) do_tick();
    chk("R9 stopped count", int'(cnt), 6);
    chk("R9 still high", int'(out), 1);
    set_gate(1);
    for (int k = 0; k <= 9; k++) step_check("R9 restart", 3, 8, k, 0);

    // R4: hardware one-shot
    do_load(1, 0, 4);
    do_tick();
    chk("R4 armed count", int'(cnt), 4);
    chk("R4 armed out", int'(out), 1);
    repeat (2) do_tick();
    chk("R4 waits for trigger", int'(cnt), 4);
    set_gate(0); set_gate(1);
    for (int k = 0; k <= 2; k++) step_check("R4 oneshot", 1, 4, k, 0);
    set_gate(0); set_gate(1);
    for (int k = 0; k <= 6; k++) step_check("R4 retrigger", 1, 4, k, 0);

    // R8: hardware strobe
    do_load(5, 0, 3);
    do_tick();
    chk("R8 armed out", int'(out), 1);
    set_gate(0); set_gate(1);
    for (int k = 0; k <= 2; k++) step_check("R8 hwstrobe", 5, 3, k, 0);
    set_gate(0); set_gate(1);
    for (int k = 0; k <= 5; k++) step_check("R8 retrigger", 5, 3, k, 0);

    // R11: codes 6 and 7
    do_load(6, 0, 3);
    for (int k = 0; k <= 7; k++) step_check("R11 code6", 2, 3, k, 0);
    do_load(7, 0, 4);
    for (int k = 0; k <= 9; k++) step_check("R11 code7", 3, 4, k, 0);

    // R7: single strobe, checked past the wrap in decimal range
    do_load(4, 1, 16'h0003);
    for (int k = 0; k <= 10006; k++) step_check("R7 once", 4, 3, k, 1);

    // random mix of gated modes
    set_gate(1);
    for (int it = 0; it < 24; it++) begin
      int md, n, steps;
      bit bcd;
      case ($urandom % 4)
        0: md = 0;
        1: md = 2;
        2: md = 3;
        default: md = 4;
      endcase
      n = 2 + int'($urandom % 49);
      bcd = 1'($urandom % 2);
      steps = 1 + int'($urandom % (3 * n));
      do_load(md, bcd, bcd ? to_bcd(n) : n);
      for (int k = 0; k <= steps; k++) begin
        case (md)
          0: step_check("R3 random", md, n, k, bcd);
          2: step_check("R5 random", md, n, k, bcd);
          3: step_check("R6 random", md, n, k, bcd);
          default: step_check("R7 random", md, n, k, bcd);
        endcase
      end
    end

    report();
    $finish;
  end

endmodule